// File: doc/BRIEF.md
# Converter Start Trigger Selector

This block decides when an analog-to-digital conversion sequence begins. A single start pulse launches a full pass over every active channel, so the sequencer needs nothing per channel. Two kinds of request can produce that pulse. One is a software strobe, which comes from a control register write and is already in the converter clock domain. The other is one hardware source out of several asynchronous lines: six timer waveform outputs, an external trigger pin and a PWM event line. A select field picks the hardware source, and an enable bit gates it.

All hardware lines pass through a two-stage synchroniser in the converter clock domain. The selected line then goes through a registered rising-edge detector. Only a rising edge starts a sequence; a level held high does not. Because the lines are sampled asynchronously, the edge-to-pulse latency varies by up to one clock.

The block emits a one-cycle `start_pulse`, and only in a cycle where the sequencer reports itself idle. A request that arrives while a sequence runs is discarded, not held. Changing the select field or the enable bit never produces a start by itself. `start_pulse` is a plain control strobe with no back-pressure: the sequencer must accept it in the cycle it appears and drop `seq_idle` in the following cycle.

Top module: `ctsel_top`

## Requirements
- R1: If `sw_start` is 1 at a clock edge, `seq_idle` is 1 and `start_pulse` is 0, then `start_pulse` is 1 in the next cycle, whatever the value of `hw_trig_en`.
- R2: `trig_sel` is decoded as follows: 0 to 5 select `tmr_wave[0]` to `tmr_wave[5]`, 6 selects `ext_trig` and 7 selects `pwm_evt`.
- R3: While `hw_trig_en` is 0, edges on the hardware lines produce no start.
- R4: A 0-to-1 change of the selected line, sampled high at edge t after being low at edge t-1, gives `start_pulse` high after edge t+2. Holding the line high gives no further pulse.
- R5: `start_pulse` lasts one cycle, and it is never high in two consecutive cycles.
- R6: A request (software or hardware) that is due while `seq_idle` is 0 is discarded. It does not appear after `seq_idle` returns to 1.
- R7: A change of `trig_sel` or `hw_trig_en` produces no start, even when the newly selected line is already high. A hardware edge that reaches the detector in the same cycle as such a change is dropped.
- R8: `start_pulse` is 0 during reset. A line that is high when reset is released causes no start, and hardware edges are honoured only from the fourth clock edge after reset release.
- R9: A software and a hardware request due in the same cycle give a single pulse.
- R10: Activity on hardware lines that are not selected has no effect on `start_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_start | input | 1 | Software start strobe, synchronous to clk |
| hw_trig_en | input | 1 | Hardware trigger enable |
| trig_sel | input | 3 | Hardware source select (encoding in R2) |
| tmr_wave | input | 6 | Timer waveform outputs, asynchronous |
| ext_trig | input | 1 | External trigger pin, asynchronous |
| pwm_evt | input | 1 | PWM event line, asynchronous |
| seq_idle | input | 1 | Sequencer idle; a start is issued only when 1 |
| start_pulse | output | 1 | One-cycle start request to the sequencer |

## Verification
A software strobe presented at edge t shows up on `start_pulse` after that same edge. A hardware line first sampled high at edge t shows up after edge t+2: two synchroniser stages, then the output register. The bench drives every input on the falling edge, so the rising edge samples it cleanly. A behavioural model keeps the last four samples of each line together with the previous select and enable values. At each rising edge the model predicts the pulse from those samples. The prediction is compared with `start_pulse` on the next falling edge, so every expected value is checked in exactly the cycle the registers make it due. Dropped requests, from a busy sequencer, a disabled source or a configuration change, are checked the same way, as cycles where the pulse must be 0.

// File: rtl/ctsel_pkg.sv
package ctsel_pkg;
  // default count of timer waveform inputs
  localparam int unsigned CTS_N_TMR = 6;
  // synchroniser depth in the converter clock domain
  localparam int unsigned CTS_SYNC_STAGES = 2;

  // edges after reset before the edge history is trustworthy
  function automatic int unsigned cts_warm_cycles(input int unsigned stages);
    return stages + 1;
  endfunction
endpackage

// File: rtl/ctsel_sync.sv
module ctsel_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  // stg[0] is the newest sample
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d_async};
  end

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/ctsel_src_mux.sv
module ctsel_src_mux #(
  parameter int unsigned NSRC  = 8,
  parameter int unsigned SEL_W = 3
) (
  input  logic [NSRC-1:0]  src,
  input  logic [SEL_W-1:0] sel,
  output logic             lvl
);
  always_comb begin
    lvl = 1'b0;
    for (int i = 0; i < int'(NSRC); i++) begin
      if (sel == SEL_W'(i)) lvl = src[i];
    end
  end
endmodule

// File: rtl/ctsel_edge.sv
module ctsel_edge #(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned WARM  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl,
  input  logic [SEL_W-1:0] sel,
  input  logic             en,
  output logic             hw_evt
);
  localparam int unsigned WW = $clog2(WARM + 1);

  logic             hist;
  logic [SEL_W-1:0] sel_q;
  logic             en_q;
  logic [WW-1:0]    warm;
  logic             cfg_chg;
  logic             warm_done;

  assign cfg_chg   = (sel != sel_q) || (en != en_q);
  assign warm_done = (warm == WW'(WARM));
  // a config change reloads history from the current level and masks that cycle
  assign hw_evt    = en && lvl && !hist && !cfg_chg && warm_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist  <= 1'b0;
      sel_q <= '0;
      en_q  <= 1'b0;
      warm  <= '0;
    end else begin
      hist  <= lvl;
      sel_q <= sel;
      en_q  <= en;
      if (!warm_done) warm <= warm + WW'(1);
    end
  end
endmodule

// File: rtl/ctsel_gate.sv
module ctsel_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_start,
  input  logic hw_evt,
  input  logic seq_idle,
  output logic start_pulse
);
  logic fire;

  // requests while busy, or right after a pulse, are dropped, not queued
  assign fire = (sw_start || hw_evt) && seq_idle && !start_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_pulse <= 1'b0;
    else        start_pulse <= fire;
  end
endmodule

// File: rtl/ctsel_top.sv
module ctsel_top
  import ctsel_pkg::*;
#(
  parameter int unsigned N_TMR       = CTS_N_TMR,
  parameter int unsigned SYNC_STAGES = CTS_SYNC_STAGES,
  parameter int unsigned NSRC        = N_TMR + 2,
  parameter int unsigned SEL_W       = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_start,
  input  logic             hw_trig_en,
  input  logic [SEL_W-1:0] trig_sel,
  input  logic [N_TMR-1:0] tmr_wave,
  input  logic             ext_trig,
  input  logic             pwm_evt,
  input  logic             seq_idle,
  output logic             start_pulse
);
  localparam int unsigned WARM = cts_warm_cycles(SYNC_STAGES);

  logic [NSRC-1:0] raw_bus;
  logic [NSRC-1:0] sync_bus;
  logic            sel_lvl;
  logic            hw_evt;

  // index order matches the select encoding: timers, external pin, PWM event
  assign raw_bus = {pwm_evt, ext_trig, tmr_wave};

  ctsel_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(raw_bus), .q_sync(sync_bus)
  );

  ctsel_src_mux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_mux (
    .src(sync_bus), .sel(trig_sel), .lvl(sel_lvl)
  );

  ctsel_edge #(.SEL_W(SEL_W), .WARM(WARM)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sel_lvl), .sel(trig_sel),
    .en(hw_trig_en), .hw_evt(hw_evt)
  );

  ctsel_gate u_gate (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .hw_evt(hw_evt),
    .seq_idle(seq_idle), .start_pulse(start_pulse)
  );
endmodule

// File: rtl/ctsel_chk.sv
module ctsel_chk #(
  parameter int unsigned SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_start,
  input logic             hw_trig_en,
  input logic [SEL_W-1:0] trig_sel,
  input logic             seq_idle,
  input logic             start_pulse
);
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  a_r6_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(seq_idle));

  a_r1_sw_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_start && seq_idle && !start_pulse) |=> start_pulse);

  a_r3_hw_gated: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> ($past(sw_start) || $past(hw_trig_en)));

  // R7: configuration change alone with no software strobe gives no start
  a_r7_cfg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_start && !$stable(trig_sel)) |=> !start_pulse);

  always_ff @(posedge clk) begin
    if (!rst_n) a_r8_reset_low: assert (!start_pulse);
  end
endmodule

bind ctsel_top ctsel_chk #(.SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .hw_trig_en(hw_trig_en),
  .trig_sel(trig_sel), .seq_idle(seq_idle), .start_pulse(start_pulse)
);

// File: tb/ctsel_top_tb.sv
module ctsel_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_start = 1'b0;
  logic       hw_trig_en = 1'b0;
  logic [2:0] trig_sel = 3'd0;
  logic [7:0] srcb = 8'h00;
  logic       seq_idle = 1'b1;
  logic       start_pulse;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctsel_top dut_i (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .hw_trig_en(hw_trig_en),
    .trig_sel(trig_sel), .tmr_wave(srcb[5:0]), .ext_trig(srcb[6]),
    .pwm_evt(srcb[7]), .seq_idle(seq_idle), .start_pulse(start_pulse)
  );

  // behavioural reference: sample history of every line plus previous config
  bit [7:0] smp [4];
  int       n_edge = 0;
  bit       exp_p = 1'b0;
  bit [2:0] sel_p = 3'd0;
  bit       en_p = 1'b0;
  string    tag = "R8";

  always @(posedge clk) begin
    bit hw;
    bit req;
    if (!rst_n) begin
      n_edge = 0;
      exp_p = 1'b0;
      for (int k = 0; k < 4; k++) smp[k] = 8'h00;
      tag = "R8";
    end else begin
      for (int k = 3; k > 0; k--) smp[k] = smp[k-1];
      smp[0] = srcb;
      n_edge++;
      hw = (n_edge >= 4) && hw_trig_en && (hw_trig_en == en_p) &&
           (trig_sel == sel_p) && smp[2][trig_sel] && !smp[3][trig_sel];
      req = sw_start || hw;
      if (req && seq_idle && !exp_p) tag = sw_start ? "R1" : "R4";
      else if (req && !seq_idle)     tag = "R6";
      else if (req)                  tag = "R5";
      else if (!hw_trig_en)          tag = "R3";
      else                           tag = "R7";
      exp_p = req && seq_idle && !exp_p;
    end
    en_p  = hw_trig_en;
    sel_p = trig_sel;
  end

  always @(negedge clk) begin
    if (!done) begin
      n_vec++;
      if (start_pulse !== exp_p) begin
        n_bad++;
        $display("FAIL %s t=%0t start_pulse actual=%b expected=%b", tag, $time, start_pulse, exp_p);
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sw_strobe();
    @(negedge clk) sw_start = 1'b1;
    @(negedge clk) sw_start = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R8: external line high and selected across reset, output held low
    trig_sel = 3'd6; hw_trig_en = 1'b1; srcb[6] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      n_vec++;
      if (start_pulse !== 1'b0) begin
        n_bad++;
        $display("FAIL R8 reset start_pulse actual=%b expected=0", start_pulse);
      end
    end
    rst_n = 1'b1;
    cyc(8);             // R8: no pulse from the line already high
    srcb[6] = 1'b0;
    cyc(4);

    // R1: software start with hardware disabled, then enabled
    hw_trig_en = 1'b0; cyc(2);
    sw_strobe(); cyc(3);
    hw_trig_en = 1'b1; cyc(2);
    sw_strobe(); cyc(3);

    // R5: strobe held three cycles gives alternate pulses only
    @(negedge clk) sw_start = 1'b1;
    cyc(3);
    sw_start = 1'b0; cyc(3);

    // R2, R4: each select value with its own line; long high gives one pulse
    for (int s = 0; s < 8; s++) begin
      trig_sel = 3'(s); cyc(4);
      srcb[s] = 1'b1; cyc(7);
      srcb[s] = 1'b0; cyc(4);
    end

    // R10: other lines toggle while timer 0 is selected
    trig_sel = 3'd0; cyc(3);
    for (int s = 1; s < 8; s++) begin
      srcb[s] = 1'b1; cyc(2);
      srcb[s] = 1'b0; cyc(2);
    end

    // R3: selected line toggles while disabled
    hw_trig_en = 1'b0; cyc(2);
    srcb[0] = 1'b1; cyc(4); srcb[0] = 1'b0; cyc(4);

    // R6: requests while the sequencer is busy are lost
    hw_trig_en = 1'b1; cyc(2);
    seq_idle = 1'b0;
    sw_strobe();
    srcb[0] = 1'b1; cyc(6);
    seq_idle = 1'b1; cyc(6);
    srcb[0] = 1'b0; cyc(4);

    // R7: switch select onto a line already high; enable onto a high line
    srcb[2] = 1'b1; trig_sel = 3'd1; cyc(5);
    trig_sel = 3'd2; cyc(6);
    hw_trig_en = 1'b0; cyc(3);
    hw_trig_en = 1'b1; cyc(6);
    srcb[2] = 1'b0; cyc(4);
    // R7: edge reaching the detector in the same cycle as a select change
    srcb[3] = 1'b1; srcb[2] = 1'b1; cyc(2);
    trig_sel = 3'd3; cyc(6);
    srcb[3] = 1'b0; srcb[2] = 1'b0; cyc(4);

    // R9: software strobe lined up with a hardware edge
    trig_sel = 3'd7; cyc(4);
    srcb[7] = 1'b1; cyc(2);
    sw_start = 1'b1; cyc(1); sw_start = 1'b0; cyc(5);
    srcb[7] = 1'b0; cyc(4);

    // mixed traffic covering R1 to R10 together
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 9) == 0) srcb[$urandom_range(0, 7)] ^= 1'b1;
      sw_start = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 49) == 0) trig_sel = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 79) == 0) hw_trig_en = ~hw_trig_en;
      if ($urandom_range(0, 7) == 0)  seq_idle = ~seq_idle;
    end
    sw_start = 1'b0;
    cyc(6);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule